// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge Select

This block arbitrates interrupts for a small 8-bit processor core. It serves two sources: a one-cycle overflow pulse from a timer, and an asynchronous external pin whose active edge is chosen by the level of a separate polarity input. That input is normally wired to a port output bit. Software sees one 8-bit control register. It holds a global enable, an enable for each source and a request flag for each source.

A request is taken when the global enable is set, the source is enabled and flagged, and the return stack is not full. In that cycle the block raises a one-cycle take strobe and presents the call vector for the core. On the clock edge that ends the cycle, it clears the global enable and the flag of the serviced source. Flags are set even while interrupts are masked. Any set flag drives a wake-up output so that a halted core can resume.

Top module: `irq_arbiter`

## Requirements
- R1: Control register layout: bit 0 global enable, bit 1 external enable, bit 2 timer enable, bit 4 external flag, bit 5 timer flag. Bits 3, 6 and 7 read 0 and ignore writes. After reset the register reads 0x00, and a write takes effect on the next clock edge.
- R2: A high `tmr_ovf_i` sampled on a clock edge sets the timer flag, which is visible after that edge.
- R3: An active pin edge sets the external flag once, visible after the third rising clock edge after the pin changes (two synchronizer stages plus the edge register). A steady pin sets nothing further.
- R4: With `edge_pol_i` high only a low-to-high pin transition is active. With it low only a high-to-low transition is active. Changing `edge_pol_i` while the pin is steady triggers nothing.
- R5: `take_o` is high in a cycle exactly when the global enable is set, `stk_full_i` is low and some source has both its enable and its flag set. `vec_o` is then 0x04 for the external source and 0x08 for the timer. `vec_o` is 0x00 when `take_o` is low.
- R6: The clock edge that ends a take cycle clears the global enable and the serviced source's flag. The other source's flag and both enables are preserved, and the take clear wins over a software write in that cycle.
- R7: While the global enable is clear, events still set their flags but no take occurs.
- R8: While `stk_full_i` is high no take occurs. An enabled pending request is taken in the first cycle after `stk_full_i` falls.
- R9: When both sources are enabled and pending, the external source is taken first. The timer is taken after software sets the global enable again.
- R10: A hardware event on a source wins over a software write of 0 to that flag in the same cycle. It also wins over the take clear of that same source.
- R11: `wake_o` is high whenever either request flag is set, regardless of the enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse, one cycle per event |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| edge_pol_i | input | 1 | Edge select: 1 rising, 0 falling |
| stk_full_i | input | 1 | Return stack is full |
| reg_wr_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 8 | Write data for the control register |
| reg_rdata_o | output | 8 | Current control register value |
| take_o | output | 1 | One-cycle take strobe to the core |
| vec_o | output | 8 | Call vector, valid while take_o is high |
| wake_o | output | 1 | Wake-up request, high while any flag is set |

## Verification
The assertions assume that `tmr_ovf_i`, `stk_full_i`, `edge_pol_i` and the register write port are synchronous to `clk` and only `ext_pin_i` is asynchronous. They also assume the core accepts every take strobe in the cycle it appears. The bench drives all synchronous inputs on the falling edge. It moves the pin only on the falling edge and holds each level for at least three cycles. It changes the polarity only while the pin is steady, so each pin transition produces at most one detected edge.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int DATA_W   = 8;
  localparam int NSRC     = 2;
  localparam int SRC_EXT  = 0;   // lower index wins arbitration
  localparam int SRC_TMR  = 1;
  localparam int GIE_BIT  = 0;
  localparam int EN_BASE  = 1;   // enable of source i at EN_BASE + i
  localparam int FLG_BASE = 4;   // flag of source i at FLG_BASE + i
  localparam logic [DATA_W-1:0] VEC_EXT = 8'h04;
  localparam logic [DATA_W-1:0] VEC_TMR = 8'h08;

  // active-edge test on synchronized pin samples
  function automatic logic edge_hit(logic pol, logic cur, logic prev);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // assemble software view of the control state
  function automatic logic [DATA_W-1:0] pack_ctrl(logic gie,
                                                  logic [NSRC-1:0] en,
                                                  logic [NSRC-1:0] flg);
    logic [DATA_W-1:0] r;
    r = '0;
    r[GIE_BIT] = gie;
    for (int i = 0; i < NSRC; i++) begin
      r[EN_BASE + i]  = en[i];
      r[FLG_BASE + i] = flg[i];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] src_vec(int idx);
    return (idx == SRC_EXT) ? VEC_EXT : VEC_TMR;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
`timescale 1ns/1ps
module irq_edge_sync
  import irq_arb_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[k] <= 1'b0;
          else        chain[k] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[k] <= 1'b0;
          else        chain[k] <= chain[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign edge_o = edge_hit(pol_i, chain[STAGES-1], prev_q);
endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   set_i,
  input  logic [NSRC-1:0]   clr_i,
  input  logic              take_i,
  output logic              gie_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   flag_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[3], wdata_i[7:6]};

  // take clear beats a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_o <= 1'b0;
    else if (take_i) gie_o <= 1'b0;
    else if (wr_i)   gie_o <= wdata_i[GIE_BIT];
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic flag_nx;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    en_o[i] <= 1'b0;
        else if (wr_i) en_o[i] <= wdata_i[EN_BASE + i];
      end

      // order: software write, then take clear, then hardware set
      always_comb begin
        flag_nx = wr_i ? wdata_i[FLG_BASE + i] : flag_o[i];
        if (clr_i[i]) flag_nx = 1'b0;
        if (set_i[i]) flag_nx = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_o[i] <= 1'b0;
        else        flag_o[i] <= flag_nx;
      end
    end
  endgenerate

  assign rdata_o = pack_ctrl(gie_o, en_o, flag_o);
endmodule

// File: rtl/irq_select.sv
`timescale 1ns/1ps
module irq_select
  import irq_arb_pkg::*;
(
  input  logic              gie_i,
  input  logic              stk_full_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [NSRC-1:0]   flag_i,
  output logic [NSRC-1:0]   grant_o,
  output logic              take_o,
  output logic [DATA_W-1:0] vec_o
);
  logic [NSRC-1:0] req;
  assign req = en_i & flag_i & {NSRC{gie_i & ~stk_full_i}};

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant_o[i]) vec_o = src_vec(i);
  end

  assign take_o = |grant_o;
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf_i,
  input  logic              ext_pin_i,
  input  logic              edge_pol_i,
  input  logic              stk_full_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              take_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              wake_o
);
  // named internal events, visible to the checker
  logic            ext_edge;
  logic [NSRC-1:0] set_evt;
  logic [NSRC-1:0] grant;
  logic            gie;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] flag;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin_i),
    .pol_i  (edge_pol_i),
    .edge_o (ext_edge)
  );

  assign set_evt[SRC_EXT] = ext_edge;
  assign set_evt[SRC_TMR] = tmr_ovf_i;

  irq_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .set_i   (set_evt),
    .clr_i   (grant),
    .take_i  (take_o),
    .gie_o   (gie),
    .en_o    (en),
    .flag_o  (flag),
    .rdata_o (reg_rdata_o)
  );

  irq_select u_sel (
    .gie_i      (gie),
    .stk_full_i (stk_full_i),
    .en_i       (en),
    .flag_i     (flag),
    .grant_o    (grant),
    .take_o     (take_o),
    .vec_o      (vec_o)
  );

  assign wake_o = |flag;
endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tmr_ovf_i,
  input logic              stk_full_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              take_o,
  input logic [DATA_W-1:0] vec_o,
  input logic              wake_o,
  input logic              ext_edge,
  input logic [NSRC-1:0]   grant
);
  a_r5_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (reg_rdata_o[GIE_BIT] && !stk_full_i));

  a_r8_stack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full_i |-> !take_o);

  a_r6_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !reg_rdata_o[GIE_BIT]);

  a_r5_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_o == VEC_EXT || vec_o == VEC_TMR));

  a_r5_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (vec_o == '0));

  a_r9_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && reg_rdata_o[FLG_BASE+SRC_EXT] && reg_rdata_o[EN_BASE+SRC_EXT])
      |-> (vec_o == VEC_EXT));

  a_r2_tmr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> reg_rdata_o[FLG_BASE+SRC_TMR]);

  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> reg_rdata_o[FLG_BASE+SRC_EXT]);

  a_r11_wake_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf_i || ext_edge) |=> wake_o);

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind irq_arbiter irq_arbiter_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tmr_ovf_i   (tmr_ovf_i),
  .stk_full_i  (stk_full_i),
  .reg_rdata_o (reg_rdata_o),
  .take_o      (take_o),
  .vec_o       (vec_o),
  .wake_o      (wake_o),
  .ext_edge    (ext_edge),
  .grant       (grant)
);

// File: tb/irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_ovf_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       edge_pol_i = 1'b0;
  logic       stk_full_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       take_o;
  logic [7:0] vec_o;
  logic       wake_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_arbiter dut_i (
    .clk (clk), .rst_n (rst_n), .tmr_ovf_i (tmr_ovf_i), .ext_pin_i (ext_pin_i),
    .edge_pol_i (edge_pol_i), .stk_full_i (stk_full_i), .reg_wr_i (reg_wr_i),
    .reg_wdata_i (reg_wdata_i), .reg_rdata_o (reg_rdata_o), .take_o (take_o),
    .vec_o (vec_o), .wake_o (wake_o)
  );

  // {wr, wdata[7:0], tmr, stk, exp_take, exp_vec[7:0], exp_reg[7:0]}
  localparam int NV = 21;
  localparam logic [27:0] TBL [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},  // idle
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h20},  // R2 R7 flag set, masked
    {1'b1, 8'h25, 1'b0, 1'b0, 1'b0, 8'h00, 8'h25},  // R1 write
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 8'h25},  // R8 stack full holds
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h08, 8'h04},  // R8 R5 R6 timer taken
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h04},
    {1'b1, 8'h07, 1'b1, 1'b0, 1'b0, 8'h00, 8'h27},  // R10 hw set beats write
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h08, 8'h06},  // R5 R6
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
    {1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 8'h00, 8'h30},  // R11 flags w/o enables
    {1'b1, 8'h37, 1'b0, 1'b0, 1'b0, 8'h00, 8'h37},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h04, 8'h26},  // R9 ext first
    {1'b1, 8'h27, 1'b0, 1'b0, 1'b0, 8'h00, 8'h27},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h08, 8'h06},  // R9 timer next
    {1'b1, 8'h32, 1'b0, 1'b0, 1'b0, 8'h00, 8'h32},
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00, 8'h37},  // R1 reserved bits 0
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 8'h26},  // R6 other flag kept
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
    {1'b1, 8'h25, 1'b0, 1'b0, 1'b0, 8'h00, 8'h25},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h08, 8'h24},  // R10 set beats take clear
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}
  };

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_reg(logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1;
    reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
    reg_wdata_i = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset reg", reg_rdata_o, 8'h00);
    check("R5 reset take", {7'b0, take_o}, 8'h00);
    check("R11 reset wake", {7'b0, wake_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] e;
      e = TBL[i];
      @(negedge clk);
      reg_wr_i    = e[27];
      reg_wdata_i = e[26:19];
      tmr_ovf_i   = e[18];
      stk_full_i  = e[17];
      #1;
      check($sformatf("R5 take v%0d", i), {7'b0, take_o}, {7'b0, e[16]});
      check($sformatf("R5 vec v%0d", i), vec_o, e[15:8]);
      @(posedge clk);
      #1;
      check($sformatf("R6 reg v%0d", i), reg_rdata_o, e[7:0]);
      check($sformatf("R11 wake v%0d", i), {7'b0, wake_o},
            {7'b0, e[4] | e[5]});
    end
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00; tmr_ovf_i = 1'b0; stk_full_i = 1'b0;

    // R4: falling polarity ignores a rising edge
    @(negedge clk); ext_pin_i = 1'b1;
    ticks(4);
    check("R4 rise ignored pol0", reg_rdata_o, 8'h00);
    // R3: falling edge, flag appears on third edge
    @(negedge clk); ext_pin_i = 1'b0;
    ticks(2);
    check("R3 latency not yet", reg_rdata_o, 8'h00);
    ticks(1);
    check("R3 flag set", reg_rdata_o, 8'h10);
    check("R11 wake ext", {7'b0, wake_o}, 8'h01);
    write_reg(8'h00);
    ticks(5);
    check("R3 single set per edge", reg_rdata_o, 8'h00);
    check("R11 wake clear", {7'b0, wake_o}, 8'h00);

    // R4: polarity change on steady pin, then rising edge
    @(negedge clk); edge_pol_i = 1'b1;
    ticks(3);
    check("R4 pol change quiet", reg_rdata_o, 8'h00);
    @(negedge clk); ext_pin_i = 1'b1;
    ticks(3);
    check("R4 rise pol1", reg_rdata_o, 8'h10);
    write_reg(8'h00);
    @(negedge clk); ext_pin_i = 1'b0;
    ticks(4);
    check("R4 fall ignored pol1", reg_rdata_o, 8'h00);

    // R8: external request waits for the stack
    write_reg(8'h03);
    @(negedge clk); stk_full_i = 1'b1; ext_pin_i = 1'b1;
    ticks(3);
    check("R8 ext pending", reg_rdata_o, 8'h13);
    @(negedge clk); #1;
    check("R8 no take when full", {7'b0, take_o}, 8'h00);
    @(negedge clk); stk_full_i = 1'b0; #1;
    check("R8 take after release", {7'b0, take_o}, 8'h01);
    check("R5 ext vector", vec_o, 8'h04);
    ticks(1);
    check("R6 ext cleared", reg_rdata_o, 8'h02);

    // R1: asynchronous reset returns register to zero
    write_reg(8'h36);
    #1;
    check("R1 pre-reset", reg_rdata_o, 8'h36);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 reset clears", reg_rdata_o, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule